// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block places a small on-chip word memory behind a set of requesters. It serves them one at a time through a single port. Besides plain loads and stores, it performs four atomic primitives: test-and-set, fetch-and-add, swap and compare-and-swap. Each atomic primitive reads a word and writes it back in two consecutive cycles. No other access can fall between that read and that write, because the unit accepts nothing until the current request has been answered.

Each requester has a valid/ready request channel. The channel carries a 3-bit opcode, a word address and two operands. Operand A is the store data, the addend, the swap value, or the expected value for compare-and-swap. Operand B is the replacement value for compare-and-swap. The answer comes back as a one-cycle pulse on that requester's `resp_valid` bit, together with the old memory word and a status bit on the shared response lines.

A four-state machine sequences every request:

- **IDLE**: picks a winner round-robin and accepts its request. The transition to READ is taken when any request is valid.
- **READ**: captures the addressed word. The machine always goes on to WRITE.
- **WRITE**: commits the computed value when the opcode calls for a write. The machine always goes on to RESP.
- **RESP**: pulses the response. The machine always returns to IDLE.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset every memory word reads 0, no `resp_valid` bit is high, and no `req_ready` bit is high while no request is valid.
- R2: A load (opcode 0) returns the addressed word with status 1 and writes nothing. A store (opcode 1) writes operand A, returns the previous word and has status 1.
- R3: Test-and-set (opcode 2) returns the old word. It writes 1 only when the old word was 0. Its status is 1 exactly when the old word was 0.
- R4: Fetch-and-add (opcode 3) returns the old word and writes old + operand A modulo 2^WIDTH, with status 1.
- R5: Swap (opcode 4) writes operand A and returns the previous word, with status 1.
- R6: Compare-and-swap (opcode 5) writes operand B and reports status 1 when operand A equals the current word. Otherwise memory is unchanged and status is 0. The old word is returned in both cases.
- R7: Arbitration is round-robin. Among the valid requesters, the grant goes to the first one found when scanning upward cyclically from the index after the last granted requester. After reset the last granted index is NREQ-1. At most one `req_ready` bit is high at a time.
- R8: Only one request is in flight. No `req_ready` bit is high between the acceptance of a request and the cycle after its response. Its read and write therefore touch the same word with no other access in between.
- R9: Every accepted request gets exactly one response, on its own requester's `resp_valid` bit. The response is visible in the third cycle after the accepting clock edge and lasts one cycle.
- R10: Opcodes 6 and 7 are reserved. They write nothing, return the old word and report status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NREQ | Request valid, one bit per requester |
| req_ready | output | NREQ | Request accepted this cycle, one-hot or zero |
| req_op | input | NREQ*3 | Opcode per requester (requester i in bits 3i+2:3i) |
| req_addr | input | NREQ*AW | Word address per requester |
| req_opa | input | NREQ*WIDTH | Operand A per requester |
| req_opb | input | NREQ*WIDTH | Operand B per requester |
| resp_valid | output | NREQ | One-cycle response pulse to the owning requester |
| resp_data | output | WIDTH | Word held at the address before the operation |
| resp_ok | output | 1 | Status of the operation |

## Verification
The interesting coincidence is several requesters raising valid in the same cycle. In the most revealing form, two of them target the same word with atomics, such as fetch-and-adds racing on one counter or compare-and-swaps racing for one lock. The bench holds all requesters valid together, so the arbiter picks one winner while the others wait. Each grant is judged against a round-robin pointer kept by the bench. Each response is judged against a behavioural memory model updated in grant order. A lost update or a double lock winner therefore shows up as a wrong old word or a wrong status.

// File: rtl/amu_pkg.sv
package amu_pkg;

    localparam int OPW = 3;

    localparam logic [OPW-1:0] OP_LOAD  = 3'd0;
    localparam logic [OPW-1:0] OP_STORE = 3'd1;
    localparam logic [OPW-1:0] OP_TAS   = 3'd2;
    localparam logic [OPW-1:0] OP_FADD  = 3'd3;
    localparam logic [OPW-1:0] OP_SWAP  = 3'd4;
    localparam logic [OPW-1:0] OP_CAS   = 3'd5;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_RESP
    } amu_state_t;

endpackage

// File: rtl/amu_rr_arbiter.sv
module amu_rr_arbiter #(
    parameter int NREQ = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREQ-1:0]         valid,
    input  logic                    advance,
    output logic [NREQ-1:0]         gnt,
    output logic [$clog2(NREQ)-1:0] gnt_idx
);
    localparam int IDXW = $clog2(NREQ);

    logic [IDXW-1:0] last_q;
    logic            found;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int k = 1; k <= NREQ; k++) begin
            int idx;
            idx = (int'(last_q) + k) % NREQ;
            if (!found && valid[idx]) begin
                found    = 1'b1;
                gnt[idx] = 1'b1;
                gnt_idx  = IDXW'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_q <= IDXW'(NREQ - 1);
        else if (advance && found)
            last_q <= gnt_idx;
    end

    a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    a_r7_grant_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~valid) == '0);

endmodule

// File: rtl/amu_alu.sv
module amu_alu #(
    parameter int WIDTH = 32
) (
    input  logic [amu_pkg::OPW-1:0] op,
    input  logic [WIDTH-1:0]        old_word,
    input  logic [WIDTH-1:0]        opa,
    input  logic [WIDTH-1:0]        opb,
    output logic                    wr_en,
    output logic [WIDTH-1:0]        new_word,
    output logic                    ok
);
    import amu_pkg::*;

    always_comb begin
        wr_en    = 1'b0;
        new_word = old_word;
        ok       = 1'b1;
        unique case (op)
            OP_LOAD: ;
            OP_STORE: begin
                wr_en    = 1'b1;
                new_word = opa;
            end
            OP_TAS: begin
                ok       = (old_word == '0);
                wr_en    = ok;
                new_word = WIDTH'(1);
            end
            OP_FADD: begin
                wr_en    = 1'b1;
                new_word = old_word + opa;
            end
            OP_SWAP: begin
                wr_en    = 1'b1;
                new_word = opa;
            end
            OP_CAS: begin
                ok       = (old_word == opa);
                wr_en    = ok;
                new_word = opb;
            end
            default: ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/amu_wordmem.sv
module amu_wordmem #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic                     we,
    input  logic [WIDTH-1:0]         wdata,
    output logic [WIDTH-1:0]         rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[i] <= '0;
            else if (we && addr == AW'(i))
                words[i] <= wdata;
        end
    end

    assign rdata = words[addr];

endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit #(
    parameter int NREQ  = 4,
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int OPW  = amu_pkg::OPW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NREQ-1:0]       req_valid,
    output logic [NREQ-1:0]       req_ready,
    input  logic [NREQ*OPW-1:0]   req_op,
    input  logic [NREQ*AW-1:0]    req_addr,
    input  logic [NREQ*WIDTH-1:0] req_opa,
    input  logic [NREQ*WIDTH-1:0] req_opb,
    output logic [NREQ-1:0]       resp_valid,
    output logic [WIDTH-1:0]      resp_data,
    output logic                  resp_ok
);
    import amu_pkg::*;

    localparam int IDXW = $clog2(NREQ);

    amu_state_t       state_q, state_d;
    logic [IDXW-1:0]  owner_q;
    logic [OPW-1:0]   op_q;
    logic [AW-1:0]    addr_q;
    logic [WIDTH-1:0] opa_q, opb_q, old_q;
    logic             ok_q;

    logic [NREQ-1:0]  gnt;
    logic [IDXW-1:0]  gnt_idx;
    logic             accept;
    logic [WIDTH-1:0] mem_rdata, alu_new;
    logic             alu_we, alu_ok, mem_we;

    assign accept = (state_q == S_IDLE) && (|req_valid);
    assign mem_we = (state_q == S_WRITE) && alu_we;

    amu_rr_arbiter #(.NREQ(NREQ)) i_arb (
        .clk(clk), .rst_n(rst_n), .valid(req_valid), .advance(accept),
        .gnt(gnt), .gnt_idx(gnt_idx)
    );

    amu_alu #(.WIDTH(WIDTH)) i_alu (
        .op(op_q), .old_word(old_q), .opa(opa_q), .opb(opb_q),
        .wr_en(alu_we), .new_word(alu_new), .ok(alu_ok)
    );

    amu_wordmem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_mem (
        .clk(clk), .rst_n(rst_n), .addr(addr_q), .we(mem_we),
        .wdata(alu_new), .rdata(mem_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept) state_d = S_READ;
            S_READ:  state_d = S_WRITE;
            S_WRITE: state_d = S_RESP;
            S_RESP:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Request capture, old-word capture, status capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner_q <= '0;
            op_q    <= '0;
            addr_q  <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
            old_q   <= '0;
            ok_q    <= 1'b0;
        end else begin
            if (accept) begin
                owner_q <= gnt_idx;
                op_q    <= req_op[gnt_idx*OPW +: OPW];
                addr_q  <= req_addr[gnt_idx*AW +: AW];
                opa_q   <= req_opa[gnt_idx*WIDTH +: WIDTH];
                opb_q   <= req_opb[gnt_idx*WIDTH +: WIDTH];
            end
            if (state_q == S_READ)  old_q <= mem_rdata;
            if (state_q == S_WRITE) ok_q  <= alu_ok;
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == S_IDLE) ? gnt : '0;
        resp_valid = '0;
        if (state_q == S_RESP) resp_valid[owner_q] = 1'b1;
        resp_data  = old_q;
        resp_ok    = (state_q == S_RESP) && ok_q;
    end

    a_r8_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |-> (req_ready == '0));
    a_r9_write_then_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRITE) |=> $onehot(resp_valid));
    a_r9_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(resp_valid));
    a_r3_tas_sets_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRITE && op_q == OP_TAS && old_q == '0) |=> (mem_rdata == WIDTH'(1)));
    a_r6_cas_fail_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRITE && op_q == OP_CAS && old_q != opa_q) |=> (mem_rdata == old_q && !resp_ok));
    a_r2_load_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRITE && op_q == OP_LOAD) |=> (mem_rdata == old_q));

endmodule

// File: tb/test_atomic_mem_unit.sv
module test_atomic_mem_unit;
    localparam int N = 4;
    localparam int W = 32;
    localparam int D = 16;
    localparam int AW = $clog2(D);
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [N-1:0]   b_valid = '0;
    logic [2:0]     b_op   [N];
    logic [AW-1:0]  b_addr [N];
    logic [W-1:0]   b_opa  [N];
    logic [W-1:0]   b_opb  [N];

    logic [N-1:0]   req_ready, resp_valid;
    logic [N*3-1:0] req_op;
    logic [N*AW-1:0] req_addr;
    logic [N*W-1:0] req_opa, req_opb;
    logic [W-1:0]   resp_data;
    logic           resp_ok;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            req_op[i*3 +: 3]    = b_op[i];
            req_addr[i*AW +: AW] = b_addr[i];
            req_opa[i*W +: W]   = b_opa[i];
            req_opb[i*W +: W]   = b_opb[i];
        end
    end

    atomic_mem_unit #(.NREQ(N), .WIDTH(W), .DEPTH(D)) i_atomic_mem_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_ok(resp_ok)
    );

    typedef struct {
        logic [W-1:0] data;
        logic         ok;
        int           due;
        logic [2:0]   op;
    } exp_t;

    exp_t         expq [N][$];
    logic [W-1:0] model_mem [D];
    int           last_gnt = N - 1;
    int           cyc = 0;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R10";
        endcase
    endfunction

    // Reference model: applies each accepted request in grant order
    task automatic model_apply(input int r);
        exp_t e;
        logic [W-1:0] old;
        old    = model_mem[b_addr[r]];
        e.data = old;
        e.ok   = 1'b1;
        e.due  = cyc + 3;
        e.op   = b_op[r];
        case (b_op[r])
            3'd0: ;
            3'd1: model_mem[b_addr[r]] = b_opa[r];
            3'd2: begin e.ok = (old == 0); if (old == 0) model_mem[b_addr[r]] = 1; end
            3'd3: model_mem[b_addr[r]] = old + b_opa[r];
            3'd4: model_mem[b_addr[r]] = b_opa[r];
            3'd5: begin e.ok = (old == b_opa[r]); if (e.ok) model_mem[b_addr[r]] = b_opb[r]; end
            default: e.ok = 1'b0;
        endcase
        expq[r].push_back(e);
    endtask

    // Per-clock comparison, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit pending;
            pending = 0;
            for (int r = 0; r < N; r++) if (expq[r].size() != 0) pending = 1;
            if (req_ready != '0) begin
                int win;
                win = -1;
                for (int k = 1; k <= N; k++) begin
                    int idx;
                    idx = (last_gnt + k) % N;
                    if (win < 0 && b_valid[idx]) win = idx;
                end
                n_checks++;
                if (pending) begin
                    n_fail++;
                    $display("FAIL R8: ready=%b while a request is in flight (expected 0)", req_ready);
                end
                n_checks++;
                if (win < 0 || req_ready != (N'(1) << win)) begin
                    n_fail++;
                    $display("FAIL R7: ready=%b expected grant index %0d", req_ready, win);
                end else begin
                    last_gnt = win;
                    model_apply(win);
                end
            end
            for (int r = 0; r < N; r++) begin
                if (resp_valid[r]) begin
                    n_checks++;
                    if (expq[r].size() == 0) begin
                        n_fail++;
                        $display("FAIL R9: unexpected response on requester %0d (expected none)", r);
                    end else begin
                        exp_t e;
                        e = expq[r].pop_front();
                        if (resp_data !== e.data || resp_ok !== e.ok || cyc != e.due) begin
                            n_fail++;
                            $display("FAIL %s/R9: req %0d data=%h ok=%b cyc=%0d expected data=%h ok=%b cyc=%0d",
                                     tag_of(e.op), r, resp_data, resp_ok, cyc, e.data, e.ok, e.due);
                        end
                    end
                end else if (expq[r].size() != 0 && expq[r][0].due <= cyc) begin
                    exp_t e;
                    e = expq[r].pop_front();
                    n_checks++;
                    n_fail++;
                    $display("FAIL R9: missing response on requester %0d at cycle %0d (expected data=%h)",
                             r, cyc, e.data);
                end
            end
        end
    end

    task automatic issue(input int r, input logic [2:0] op, input int addr,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        b_op[r]   = op;
        b_addr[r] = AW'(addr);
        b_opa[r]  = a;
        b_opb[r]  = b;
        b_valid[r] = 1'b1;
        do @(negedge clk); while (!req_ready[r]);
        @(posedge clk);
        #1 b_valid[r] = 1'b0;
    endtask

    task automatic drain();
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        finished = 1;
        for (int r = 0; r < N; r++) begin
            n_checks++;
            if (expq[r].size() != 0) begin
                n_fail++;
                $display("FAIL R9: requester %0d has %0d unanswered requests (expected 0)", r, expq[r].size());
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < D; i++) model_mem[i] = '0;
        for (int i = 0; i < N; i++) begin
            b_op[i] = '0; b_addr[i] = '0; b_opa[i] = '0; b_opb[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (resp_valid !== '0 || req_ready !== '0) begin
            n_fail++;
            $display("FAIL R1: resp_valid=%b req_ready=%b expected 0 and 0", resp_valid, req_ready);
        end
        @(posedge clk); #1;

        // R1: reset contents; R2: load/store
        issue(0, 3'd0, 0, 0, 0);
        issue(0, 3'd0, 15, 0, 0);
        issue(0, 3'd1, 3, 32'hDEADBEEF, 0);
        issue(0, 3'd0, 3, 0, 0);
        // R3: test-and-set on free, then on held word
        issue(1, 3'd2, 5, 0, 0);
        issue(1, 3'd2, 5, 0, 0);
        issue(1, 3'd0, 5, 0, 0);
        // R4: fetch-and-add with wrap
        issue(2, 3'd1, 7, 2, 0);
        issue(2, 3'd3, 7, 32'hFFFF_FFFF, 0);
        issue(2, 3'd0, 7, 0, 0);
        // R5: swap
        issue(3, 3'd4, 3, 32'h1234, 0);
        // R6: compare-and-swap hit, then miss
        issue(3, 3'd5, 3, 32'h1234, 32'h55);
        issue(3, 3'd5, 3, 32'h1234, 32'h66);
        issue(3, 3'd0, 3, 0, 0);
        // R10: reserved opcodes leave memory alone
        issue(0, 3'd6, 3, 9, 9);
        issue(0, 3'd7, 3, 9, 9);
        issue(0, 3'd0, 3, 0, 0);
        drain();

        // R7/R8: all requesters race on one counter, one lock
        fork
            for (int k = 0; k < 6; k++) issue(0, 3'd3, 9, 1, 0);
            for (int k = 0; k < 6; k++) issue(1, 3'd3, 9, 2, 0);
            for (int k = 0; k < 6; k++) issue(2, 3'd3, 9, 3, 0);
            for (int k = 0; k < 6; k++) begin
                issue(3, 3'd3, 9, 4, 0);
                issue(3, 3'd2, 10, 0, 0);
            end
        join
        drain();
        issue(0, 3'd0, 9, 0, 0);

        // R6/R7: compare-and-swap race for one word, only one winner
        fork
            issue(1, 3'd5, 11, 0, 32'h11);
            issue(2, 3'd5, 11, 0, 32'h22);
            issue(3, 3'd5, 11, 0, 32'h33);
        join
        drain();
        issue(0, 3'd0, 11, 0, 0);
        drain();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete (expected completion)");
            finish_run();
        end
    end

endmodule